// File: doc/BRIEF.md
# Audio Sample FIFO with Direction-Aware Fill Classifier

This block is a single-clock first-in first-out buffer for audio samples that sits between a sample producer and a sample consumer. Samples enter on a push port (`push_valid` with `push_ready` back-pressure) and leave on a pop port (`pop_ready` request with `pop_valid` availability). The sample chosen by a pop handshake appears on `pop_data` one clock later and stays there until the next successful pop.

Beside the data path, the block reports how full it is as a 3-bit level code and raises a service request flag. The meaning of both depends on the direction input `tx_mode`. When `tx_mode` is 1 the buffer feeds an outgoing stream: the request asks the host to supply more samples, and the quarter boundaries of the level code count toward the lower code. When `tx_mode` is 0 the buffer collects an incoming stream: the request asks the host to drain samples, and the boundaries count toward the higher code. A one-cycle error pulse marks an overrun (receive direction) or an underrun (transmit direction).

Top module: `afifo_lvl_top`

## Requirements
- R1: After reset the buffer is empty: `level_code` is 0, `pop_valid` is 0, `push_ready` is 1 and `xrun_err` is 0.
- R2: Samples leave in the order they were accepted. A pop with `pop_ready`=1 and `pop_valid`=1 at a clock edge shows the oldest sample on `pop_data` right after that edge.
- R3: A push while the buffer holds DEPTH samples (`push_ready`=0) is dropped. The stored contents and the fill count do not change.
- R4: A pop while the buffer is empty (`pop_valid`=0) leaves `pop_data` at the last popped value and leaves the count unchanged.
- R5: With `tx_mode`=1 and a fill count c where 0<c<DEPTH, the level code is 1 for c ≤ DEPTH/4, 2 for DEPTH/4 < c ≤ DEPTH/2, 3 for DEPTH/2 < c ≤ 3·DEPTH/4, and 4 above that.
- R6: With `tx_mode`=0 and a fill count c where 0<c<DEPTH, the level code is 1 for c < DEPTH/4, 2 for DEPTH/4 ≤ c < DEPTH/2, 3 for DEPTH/2 ≤ c < 3·DEPTH/4, and 4 from 3·DEPTH/4 upward.
- R7: In both directions the level code is 0 exactly when the buffer is empty and 5 exactly when it is full. Codes 6 and 7 never appear.
- R8: With `tx_mode`=1, `fifo_req` is 1 exactly when the fill count is at most DEPTH/2.
- R9: With `tx_mode`=0, `fifo_req` is 1 exactly when the fill count is at least DEPTH/4.
- R10: With `tx_mode`=0, a push attempted while full raises `xrun_err` for the one cycle after that edge. With `tx_mode`=1, the same dropped push raises no error.
- R11: With `tx_mode`=1, a pop attempted while empty raises `xrun_err` for the one cycle after that edge. With `tx_mode`=0, the same ignored pop raises no error.
- R12: A push and a pop in the same cycle, when the buffer is neither empty nor full, are both performed and the fill count stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_mode | input | 1 | 1 = transmit direction, 0 = receive direction |
| push_valid | input | 1 | Producer offers a sample |
| push_data | input | DW | Sample to store |
| push_ready | output | 1 | Buffer can accept a sample (not full) |
| pop_ready | input | 1 | Consumer asks for a sample |
| pop_valid | output | 1 | Buffer holds at least one sample |
| pop_data | output | DW | Most recently popped sample |
| level_code | output | 3 | Fill classification, 0 to 5 |
| fifo_req | output | 1 | Service request: write more (transmit) or read out (receive) |
| xrun_err | output | 1 | One-cycle overrun/underrun pulse |

## Verification
On every cycle the assertions check that the count never passes DEPTH, that the extreme level codes agree with the handshake outputs, that the request flag fits the level bands in each direction, that an error pulse only follows a blocked access, and that a pop on empty leaves the output sample unchanged. The exact band edges in each direction, first-in first-out ordering, and the direction-dependent choice of which blocked access counts as an error can only be shown by the bench. It sweeps every fill count from empty to full and back, checks both directions at each count, and compares against bands computed arithmetically.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

  typedef enum logic [2:0] {
    LVL_EMPTY = 3'd0,
    LVL_Q1    = 3'd1,
    LVL_Q2    = 3'd2,
    LVL_Q3    = 3'd3,
    LVL_Q4    = 3'd4,
    LVL_FULL  = 3'd5
  } lvl_code_t;

  // Band classification. Transmit counts a boundary into the lower band,
  // receive into the upper one.
  function automatic lvl_code_t lvl_classify(input int unsigned cnt,
                                             input int unsigned depth,
                                             input logic tx);
    int unsigned q;
    q = depth / 4;
    if (cnt == 0)           return LVL_EMPTY;
    if (cnt >= depth)       return LVL_FULL;
    if (tx) begin
      if (cnt <= q)         return LVL_Q1;
      if (cnt <= 2 * q)     return LVL_Q2;
      if (cnt <= 3 * q)     return LVL_Q3;
      return LVL_Q4;
    end
    if (cnt < q)            return LVL_Q1;
    if (cnt < 2 * q)        return LVL_Q2;
    if (cnt < 3 * q)        return LVL_Q3;
    return LVL_Q4;
  endfunction

  // Service request: transmit wants data at or below half, receive wants
  // draining from one quarter upward.
  function automatic logic req_needed(input int unsigned cnt,
                                      input int unsigned depth,
                                      input logic tx);
    if (tx) return (2 * cnt) <= depth;
    return (4 * cnt) >= depth;
  endfunction

endpackage

// File: rtl/afifo_store.sv
module afifo_store #(
  parameter int DEPTH = 8,
  parameter int DW    = 16,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign full  = (count == FULL_CNT);
  assign empty = (count == '0);

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      rd_data <= '0;
    end else begin
      if (wr_en) wr_ptr <= ptr_next(wr_ptr);
      if (rd_en) begin
        rd_ptr  <= ptr_next(rd_ptr);
        rd_data <= mem[rd_ptr];
      end
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R3: occupancy never exceeds the storage size
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);

  // R12: a paired write and read leaves occupancy unchanged
  a_r12_pair_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en) |=> $stable(count));

endmodule

// File: rtl/afifo_lvl_class.sv
module afifo_lvl_class
  import afifo_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] count,
  input  logic          tx_mode,
  output lvl_code_t     level,
  output logic          req
);

  always_comb begin
    level = lvl_classify(32'(count), DEPTH, tx_mode);
    req   = req_needed(32'(count), DEPTH, tx_mode);
  end

endmodule

// File: rtl/afifo_xrun.sv
module afifo_xrun (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_mode,
  input  logic push_blocked,
  input  logic pop_blocked,
  output logic err_pulse
);

  logic overrun_evt, underrun_evt;

  assign overrun_evt  = push_blocked && !tx_mode;
  assign underrun_evt = pop_blocked  &&  tx_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_pulse <= 1'b0;
    else        err_pulse <= overrun_evt || underrun_evt;
  end

  // R10: an overrun is never reported in the transmit direction
  a_r10_no_tx_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tx_mode && push_blocked && !pop_blocked) |-> !err_pulse);

  // R11: an underrun is never reported in the receive direction
  a_r11_no_rx_underrun: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!tx_mode && pop_blocked && !push_blocked) |-> !err_pulse);

endmodule

// File: rtl/afifo_lvl_top.sv
module afifo_lvl_top
  import afifo_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_mode,
  input  logic          push_valid,
  input  logic [DW-1:0] push_data,
  output logic          push_ready,
  input  logic          pop_ready,
  output logic          pop_valid,
  output logic [DW-1:0] pop_data,
  output logic [2:0]    level_code,
  output logic          fifo_req,
  output logic          xrun_err
);

  initial begin
    if ((DEPTH % 4) != 0 || DEPTH < 4)
      $error("afifo_lvl_top: DEPTH must be a positive multiple of 4");
  end

  logic [CW-1:0] count;
  logic          full, empty;
  logic          push_fire, pop_fire;
  logic          push_blocked, pop_blocked;
  lvl_code_t     level;

  assign push_ready   = !full;
  assign pop_valid    = !empty;
  assign push_fire    = push_valid && !full;
  assign pop_fire     = pop_ready  && !empty;
  assign push_blocked = push_valid &&  full;
  assign pop_blocked  = pop_ready  &&  empty;

  afifo_store #(.DEPTH(DEPTH), .DW(DW)) store_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (push_fire),
    .wr_data (push_data),
    .rd_en   (pop_fire),
    .rd_data (pop_data),
    .count   (count),
    .full    (full),
    .empty   (empty)
  );

  afifo_lvl_class #(.DEPTH(DEPTH)) class_i (
    .count   (count),
    .tx_mode (tx_mode),
    .level   (level),
    .req     (fifo_req)
  );

  afifo_xrun xrun_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_mode      (tx_mode),
    .push_blocked (push_blocked),
    .pop_blocked  (pop_blocked),
    .err_pulse    (xrun_err)
  );

  assign level_code = level;

  // R7: full code only while pushes are refused
  a_r7_full_code: assert property (@(posedge clk) disable iff (!rst_n)
    (level == LVL_FULL) |-> !push_ready);

  // R7: empty code only while nothing is poppable
  a_r7_empty_code: assert property (@(posedge clk) disable iff (!rst_n)
    (level == LVL_EMPTY) |-> !pop_valid);

  // R7: reserved codes never leave the block
  a_r7_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    level_code <= 3'd5);

  // R8: lower two nonempty bands in transmit always request data
  a_r8_tx_req_low: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mode && (level == LVL_Q1 || level == LVL_Q2 || level == LVL_EMPTY)) |-> fifo_req);

  // R8: upper bands in transmit never request data
  a_r8_tx_req_high: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mode && (level == LVL_Q3 || level == LVL_Q4 || level == LVL_FULL)) |-> !fifo_req);

  // R9: receive requests draining from the second band upward
  a_r9_rx_req: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_mode && level != LVL_EMPTY && level != LVL_Q1) |-> fifo_req);

  // R4: a refused pop leaves the output sample untouched
  a_r4_pop_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ready && !pop_valid) |=> $stable(pop_data));

  // R10/R11: an error pulse only follows a blocked access
  a_r10_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    xrun_err |-> $past((push_valid && !push_ready) || (pop_ready && !pop_valid)));

endmodule

// File: tb/afifo_lvl_top_tb_top.sv
module afifo_lvl_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int DW    = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tx_mode;
  logic          push_valid;
  logic [DW-1:0] push_data;
  logic          push_ready;
  logic          pop_ready;
  logic          pop_valid;
  logic [DW-1:0] pop_data;
  logic [2:0]    level_code;
  logic          fifo_req;
  logic          xrun_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  int model_q[$];
  int last_pop = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  afifo_lvl_top #(.DEPTH(DEPTH), .DW(DW)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_mode    (tx_mode),
    .push_valid (push_valid),
    .push_data  (push_data),
    .push_ready (push_ready),
    .pop_ready  (pop_ready),
    .pop_valid  (pop_valid),
    .pop_data   (pop_data),
    .level_code (level_code),
    .fifo_req   (fifo_req),
    .xrun_err   (xrun_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Bands restated as quarter arithmetic: transmit rounds 4c/D up,
  // receive rounds it down and adds one.
  function automatic int exp_level(input int c, input bit tx);
    if (c == 0) return 0;
    if (c == DEPTH) return 5;
    if (tx) return (4 * c + DEPTH - 1) / DEPTH;
    return (4 * c) / DEPTH + 1;
  endfunction

  function automatic int exp_req(input int c, input bit tx);
    if (tx) return (c <= DEPTH / 2) ? 1 : 0;
    return (c >= DEPTH / 4) ? 1 : 0;
  endfunction

  // Look at the status outputs in both directions for the present count.
  task automatic sweep_modes(input string tag);
    int c;
    c = model_q.size();
    for (int m = 0; m < 2; m++) begin
      tx_mode = m[0];
      #1;
      chk({tag, (m != 0) ? " R5 tx level" : " R6 rx level"}, int'(level_code), exp_level(c, m[0]));
      chk({tag, (m != 0) ? " R8 tx req" : " R9 rx req"}, int'(fifo_req), exp_req(c, m[0]));
      chk({tag, " R7 full/ready"}, int'(push_ready), (c < DEPTH) ? 1 : 0);
      chk({tag, " R7 empty/valid"}, int'(pop_valid), (c > 0) ? 1 : 0);
    end
  endtask

  // One clock with the given strobes. Inputs change away from the edge.
  task automatic step(input bit push, input int data, input bit pop, input bit tx);
    int c;
    bit exp_err;
    bit do_push, do_pop;
    c = model_q.size();
    exp_err = (push && c == DEPTH && !tx) || (pop && c == 0 && tx);
    do_push = push && (c < DEPTH);
    do_pop  = pop && (c > 0);
    tx_mode    = tx;
    push_valid = push;
    push_data  = DW'(data);
    pop_ready  = pop;
    @(posedge clk);
    #1;
    push_valid = 1'b0;
    pop_ready  = 1'b0;
    if (do_pop) last_pop = model_q.pop_front();
    if (do_push) model_q.push_back(data);
    chk(pop ? "R2/R4 pop_data" : "R2 pop_data hold", int'(pop_data), last_pop);
    chk(tx ? "R11/R10 tx err" : "R10/R11 rx err", int'(xrun_err), int'(exp_err));
    chk("R3/R12 level", int'(level_code), exp_level(model_q.size(), tx));
  endtask

  initial begin
    rst_n      = 1'b0;
    tx_mode    = 1'b1;
    push_valid = 1'b0;
    push_data  = '0;
    pop_ready  = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1 level", int'(level_code), 0);
    chk("R1 pop_valid", int'(pop_valid), 0);
    chk("R1 push_ready", int'(push_ready), 1);
    chk("R1 xrun_err", int'(xrun_err), 0);

    // Fill upward, sweeping both directions at every count.
    for (int k = 0; k < DEPTH; k++) begin
      sweep_modes("fill");
      step(1'b1, 16'h0A00 + k, 1'b0, k[0]);
    end
    sweep_modes("full");

    // R3/R10: blocked push in transmit: dropped, no error.
    step(1'b1, 16'hDEAD, 1'b0, 1'b1);
    // R10: blocked push in receive: overrun pulse for one cycle.
    step(1'b1, 16'hBEEF, 1'b0, 1'b0);
    step(1'b0, 0, 1'b0, 1'b0);
    chk("R10 pulse ends", int'(xrun_err), 0);

    // Drain to half, then paired push and pop (R12).
    for (int k = 0; k < DEPTH / 2; k++) begin
      step(1'b0, 0, 1'b1, 1'b0);
      sweep_modes("drain");
    end
    step(1'b1, 16'h0C01, 1'b1, 1'b1);
    sweep_modes("R12 pair");
    step(1'b1, 16'h0C02, 1'b1, 1'b0);
    sweep_modes("R12 pair");

    // Drain the rest; ordering checked on each pop (R2).
    while (model_q.size() > 0) begin
      step(1'b0, 0, 1'b1, model_q.size() % 2 == 0);
      sweep_modes("drain");
    end

    // R4/R11: pop on empty in receive: ignored, no error.
    step(1'b0, 0, 1'b1, 1'b0);
    // R11: pop on empty in transmit: underrun pulse, data held.
    step(1'b0, 0, 1'b1, 1'b1);
    step(1'b0, 0, 1'b0, 1'b1);
    chk("R11 pulse ends", int'(xrun_err), 0);
    sweep_modes("end");

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule